// File: doc/BRIEF.md
# Box-Muller Gaussian Noise Generator

This block produces a continuous stream of pairs of normally distributed random samples for channel emulation, dithering or noise injection. Two 32-bit uniform sources feed a fixed-point Box-Muller transform. The radius term, the square root of minus two times the natural log of the first uniform word, uses logarithmic segments picked by the word's leading-zero count. A first-order table interpolates the log of the mantissa. The square root is found by normalising its operand into [1,4) by an even power of two, then applying a linear table over uniform segments. The angle term takes a quadrant from the top two bits of the second uniform word and evaluates a single quarter-wave sine table, used once directly for sine and once on the complemented phase for cosine.

Every enabled clock yields one transform and therefore two samples: one from the sine branch and one from the cosine branch. Each sample is a signed 16-bit value with 11 fractional bits, so one standard deviation is 2048. The uniform word width sets the tail limit at about ±6.66 standard deviations, and the sample rate does not depend on it. A seed port restarts both sources so that a sequence can be repeated.

Top module: `gng_box_muller`

## Requirements
- R1: While synchronous active-high reset is high, and after it is released, `valid_o` is low and both samples read zero until the pipeline has filled.
- R2: A cycle advances the pipeline only when `en` is high and `seed_load` is low. `valid_o` rises on the 6th advancing clock edge after reset or a seed load, and no earlier.
- R3: In a cycle with `en` low and `seed_load` low, `valid_o`, `sample_sin_o` and `sample_cos_o` keep their values.
- R4: A clock edge with `seed_load` high loads the first source with `seed_i` and the second with `seed_i` XOR 32'h9E3779B9, substituting 32'h00000001 for an all-zero state. `valid_o` is low after that edge. The same seed always gives the same sample sequence, and different seeds give different sequences.
- R5: Samples are two's complement with 11 fractional bits (value 2048 is one standard deviation). The mean of |x| is within 0.77 to 0.83 standard deviations, and |x| never exceeds 13700.
- R6: Over 100000 transforms, each branch has a mean within ±0.03 standard deviations.
- R7: Over 100000 transforms, each branch has a variance between 0.95 and 1.05.
- R8: Over 100000 transforms, the correlation coefficient between the sine and cosine branches has magnitude below 0.03.
- R9: Over 200000 samples, the fraction with |x| above 3 standard deviations lies between 0.0015 and 0.0040.
- R10: Loading seed value zero gives a working sequence: it is not constant, and its variance over 2000 transforms lies between 0.85 and 1.15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the sources and the pipeline by one step |
| seed_load | input | 1 | Load both sources from `seed_i` and clear the valid pipeline |
| seed_i | input | 32 | Seed value |
| valid_o | output | 1 | Samples are from a fully processed transform |
| sample_sin_o | output | 16 | Sine-branch sample, signed, 11 fractional bits |
| sample_cos_o | output | 16 | Cosine-branch sample, signed, 11 fractional bits |

## Verification
The pipeline has six registers between the uniform state and the outputs. After reset or a seed load, the first valid pair therefore appears on the sixth advancing edge. The bench counts only edges on which `en` was high, including a run where `en` toggles every cycle, and it samples on the falling edge after each one. A stalled cycle is due to show no change on the very next falling edge, and the bench checks this over several stalled cycles. The statistical checks take one pair per falling edge, and only while `valid_o` is high, so that none of the fill cycles leak into the sums.

// File: rtl/gng_pkg.sv
package gng_pkg;

    localparam int UW        = 32;            // uniform word width
    localparam int OW        = 16;            // sample width
    localparam int OFRAC     = 11;            // fractional bits of a sample
    localparam int LAT       = 6;             // advancing edges from state to output
    localparam int TRIG_DLY  = 2;             // extra trig stages to meet the radius
    localparam int LN_SEGB   = 3;             // log mantissa segments = 2**LN_SEGB
    localparam int LN_FRB    = 13;
    localparam int SQ_FRB    = 12;
    localparam int TR_SEGB   = 4;             // quarter-wave segments = 2**TR_SEGB
    localparam int TR_FRB    = 12;
    localparam int PH_W      = TR_SEGB + TR_FRB;
    localparam int U1_W      = 2 + PH_W;      // quadrant + phase bits used
    localparam int EW        = 22;            // -2 ln u, 16 fractional bits
    localparam int SQW       = 16;            // normalised sqrt operand, Q2.14
    localparam int TRW       = 18;            // signed trig value, Q2.15
    localparam logic [15:0] LN2_Q16   = 16'd45426;
    localparam logic [31:0] LFSR_MASK = 32'h8020_0003;
    localparam logic [31:0] ZERO_SUB  = 32'h0000_0001;

    typedef struct packed {
        logic signed [TRW-1:0] s;
        logic signed [TRW-1:0] c;
    } trig_pair_t;

    typedef struct packed {
        logic [1:0]         quad;
        logic [TR_SEGB-1:0] si;
        logic [TR_FRB-1:0]  sf;
        logic [TR_SEGB-1:0] ci;
        logic [TR_FRB-1:0]  cf;
    } trig_dec_t;

    // ln(1 + i/8) in Q0.16, i = 0..8
    function automatic logic [15:0] ln_knot(input logic [3:0] i);
        case (i)
            4'd0: return 16'd0;
            4'd1: return 16'd7719;
            4'd2: return 16'd14624;
            4'd3: return 16'd20870;
            4'd4: return 16'd26573;
            4'd5: return 16'd31818;
            4'd6: return 16'd36675;
            4'd7: return 16'd41197;
            default: return 16'd45426;
        endcase
    endfunction

    // sqrt(1 + i/4) in Q2.14, i = 0..12
    function automatic logic [15:0] sqrt_knot(input logic [3:0] i);
        case (i)
            4'd0:  return 16'd16384;
            4'd1:  return 16'd18318;
            4'd2:  return 16'd20066;
            4'd3:  return 16'd21674;
            4'd4:  return 16'd23170;
            4'd5:  return 16'd24576;
            4'd6:  return 16'd25905;
            4'd7:  return 16'd27170;
            4'd8:  return 16'd28378;
            4'd9:  return 16'd29537;
            4'd10: return 16'd30652;
            4'd11: return 16'd31727;
            default: return 16'd32768;
        endcase
    endfunction

    // sin(i*pi/32) in Q1.15, i = 0..16
    function automatic logic [16:0] sin_knot(input logic [4:0] i);
        case (i)
            5'd0:  return 17'd0;
            5'd1:  return 17'd3212;
            5'd2:  return 17'd6393;
            5'd3:  return 17'd9512;
            5'd4:  return 17'd12540;
            5'd5:  return 17'd15447;
            5'd6:  return 17'd18205;
            5'd7:  return 17'd20788;
            5'd8:  return 17'd23170;
            5'd9:  return 17'd25330;
            5'd10: return 17'd27246;
            5'd11: return 17'd28899;
            5'd12: return 17'd30274;
            5'd13: return 17'd31357;
            5'd14: return 17'd32138;
            5'd15: return 17'd32610;
            default: return 17'd32768;
        endcase
    endfunction

    function automatic logic [5:0] clz32(input logic [31:0] v);
        logic [5:0] n;
        logic       hit;
        n   = 6'd32;
        hit = 1'b0;
        for (int b = 31; b >= 0; b--) begin
            if (!hit && v[b]) begin
                n   = 6'(31 - b);
                hit = 1'b1;
            end
        end
        return n;
    endfunction

    function automatic logic [4:0] msb22(input logic [EW-1:0] v);
        logic [4:0] p;
        p = 5'd0;
        for (int b = 0; b < EW; b++) begin
            if (v[b]) p = 5'(b);
        end
        return p;
    endfunction

    // 32 Galois steps per call: a fresh word every cycle
    function automatic logic [31:0] lfsr_leap(input logic [31:0] st);
        logic [31:0] x;
        x = st;
        for (int i = 0; i < UW; i++) begin
            x = x[0] ? ((x >> 1) ^ LFSR_MASK) : (x >> 1);
        end
        return x;
    endfunction

endpackage

// File: rtl/gng_urng.sv
module gng_urng
    import gng_pkg::*;
#(
    parameter logic [31:0] XOR_KEY    = 32'h0,
    parameter logic [31:0] RESET_SEED = 32'h1234_5678,
    parameter int          OUT_W      = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             load,
    input  logic [31:0]      seed,
    output logic [OUT_W-1:0] u
);
    logic [31:0] state;
    logic [31:0] keyed;
    logic [31:0] rst_val;

    assign keyed   = seed ^ XOR_KEY;
    assign rst_val = ((RESET_SEED ^ XOR_KEY) == 32'h0) ? ZERO_SUB : (RESET_SEED ^ XOR_KEY);

    always_ff @(posedge clk) begin
        if (rst)       state <= rst_val;
        else if (load) state <= (keyed == 32'h0) ? ZERO_SUB : keyed;
        else if (adv)  state <= lfsr_leap(state);
    end

    assign u = state[UW-1 -: OUT_W];

    // R10: a zero seed never leaves the source stuck at zero
    p_state_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
        load |=> (state != 32'h0));
    p_adv_changes_state_r10: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> (state != $past(state)));

endmodule

// File: rtl/gng_radius.sv
module gng_radius
    import gng_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [UW-1:0] u0,
    output logic [OW-1:0] radius
);
    // stage 1: logarithmic segment from the leading-zero count
    logic [5:0]        s1_kp1;
    logic [LN_SEGB-1:0] s1_idx;
    logic [LN_FRB-1:0] s1_frac;
    logic [5:0]        kp1_c;
    logic [15:0]       mant_c;

    always_comb begin
        kp1_c  = clz32(u0) + 6'd1;
        mant_c = 16'((u0 << kp1_c) >> 16);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_kp1 <= '0; s1_idx <= '0; s1_frac <= '0;
        end else if (adv) begin
            s1_kp1  <= kp1_c;
            s1_idx  <= mant_c[15 -: LN_SEGB];
            s1_frac <= mant_c[15-LN_SEGB -: LN_FRB];
        end
    end

    // stage 2: linear ln(1+m)
    logic [15:0] s2_lnq;
    logic [5:0]  s2_kp1;
    logic [15:0] ln_lo, ln_hi;
    logic [28:0] ln_prod;

    always_comb begin
        ln_lo   = ln_knot({1'b0, s1_idx});
        ln_hi   = ln_knot({1'b0, s1_idx} + 4'd1);
        ln_prod = 29'(ln_hi - ln_lo) * 29'(s1_frac);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_lnq <= '0; s2_kp1 <= '0;
        end else if (adv) begin
            s2_lnq <= ln_lo + 16'(ln_prod >> LN_FRB);
            s2_kp1 <= s1_kp1;
        end
    end

    // stage 3: e = 2 * ((k+1) ln2 - ln(1+m)), Q6.16
    logic [EW-1:0] s3_e;
    logic [EW-1:0] kln_c;
    assign kln_c = EW'(s2_kp1) * EW'(LN2_Q16);

    always_ff @(posedge clk) begin
        if (rst)      s3_e <= '0;
        else if (adv) s3_e <= (kln_c - EW'(s2_lnq)) << 1;
    end

    // stage 4: scale by an even power of two into [1,4)
    logic [SQW-1:0] s4_x;
    logic [3:0]     s4_sh;
    logic           s4_zero;
    logic [3:0]     sh_c;

    assign sh_c = 4'(msb22(s3_e) >> 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            s4_x <= '0; s4_sh <= '0; s4_zero <= 1'b1;
        end else if (adv) begin
            s4_x    <= SQW'((36'(s3_e) << 14) >> {sh_c, 1'b0});
            s4_sh   <= sh_c;
            s4_zero <= (s3_e == '0);
        end
    end

    // stage 5: linear sqrt on [1,4), then undo the scaling
    logic [3:0]  sq_seg;
    logic [15:0] sq_lo, sq_hi, sq_c;
    logic [27:0] sq_prod;

    always_comb begin
        sq_seg  = s4_x[15:12] - 4'd4;
        sq_lo   = sqrt_knot(sq_seg);
        sq_hi   = sqrt_knot(sq_seg + 4'd1);
        sq_prod = 28'(sq_hi - sq_lo) * 28'(s4_x[SQ_FRB-1:0]);
        sq_c    = sq_lo + 16'(sq_prod >> SQ_FRB);
    end

    always_ff @(posedge clk) begin
        if (rst)          radius <= '0;
        else if (adv)     radius <= s4_zero ? '0 : OW'((32'(sq_c) << s4_sh) >> 11);
    end

    p_norm_range_r5: assert property (@(posedge clk) disable iff (rst)
        !s4_zero |-> (s4_x >= 16'd16384));
    p_radius_bound_r5: assert property (@(posedge clk) disable iff (rst)
        radius <= 16'd13700);

endmodule

// File: rtl/gng_trig.sv
module gng_trig
    import gng_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic [U1_W-1:0] u1,
    output trig_pair_t      trig
);
    // stage 1: quadrant and phase split
    trig_dec_t      s1;
    logic [PH_W-1:0] ph_c, phn_c;

    assign ph_c  = u1[PH_W-1:0];
    assign phn_c = ~ph_c;

    always_ff @(posedge clk) begin
        if (rst) s1 <= '0;
        else if (adv) begin
            s1.quad <= u1[U1_W-1 -: 2];
            s1.si   <= ph_c[PH_W-1 -: TR_SEGB];
            s1.sf   <= ph_c[TR_FRB-1:0];
            s1.ci   <= phn_c[PH_W-1 -: TR_SEGB];
            s1.cf   <= phn_c[TR_FRB-1:0];
        end
    end

    // stage 2: quarter-wave magnitudes
    logic [16:0] s_lo, s_hi, c_lo, c_hi;
    logic [28:0] s_prod, c_prod;
    logic [16:0] s2_smag, s2_cmag;
    logic [1:0]  s2_quad;

    always_comb begin
        s_lo   = sin_knot({1'b0, s1.si});
        s_hi   = sin_knot({1'b0, s1.si} + 5'd1);
        c_lo   = sin_knot({1'b0, s1.ci});
        c_hi   = sin_knot({1'b0, s1.ci} + 5'd1);
        s_prod = 29'(s_hi - s_lo) * 29'(s1.sf);
        c_prod = 29'(c_hi - c_lo) * 29'(s1.cf);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_smag <= '0; s2_cmag <= '0; s2_quad <= '0;
        end else if (adv) begin
            s2_smag <= s_lo + 17'(s_prod >> TR_FRB);
            s2_cmag <= c_lo + 17'(c_prod >> TR_FRB);
            s2_quad <= s1.quad;
        end
    end

    // stage 3: quadrant folding
    logic signed [TRW-1:0] ps, pc;
    trig_pair_t            fold_c;

    always_comb begin
        ps = $signed({1'b0, s2_smag});
        pc = $signed({1'b0, s2_cmag});
        case (s2_quad)
            2'd0:    begin fold_c.s = ps;  fold_c.c = pc;  end
            2'd1:    begin fold_c.s = pc;  fold_c.c = -ps; end
            2'd2:    begin fold_c.s = -ps; fold_c.c = -pc; end
            default: begin fold_c.s = -pc; fold_c.c = ps;  end
        endcase
    end

    trig_pair_t dly [TRIG_DLY+1];

    always_ff @(posedge clk) begin
        if (rst)      dly[0] <= '0;
        else if (adv) dly[0] <= fold_c;
    end

    for (genvar g = 1; g <= TRIG_DLY; g++) begin : g_align
        always_ff @(posedge clk) begin
            if (rst)      dly[g] <= '0;
            else if (adv) dly[g] <= dly[g-1];
        end
    end

    assign trig = dly[TRIG_DLY];

    p_trig_unit_r5: assert property (@(posedge clk) disable iff (rst)
        (s2_smag <= 17'd32768) && (s2_cmag <= 17'd32768));

endmodule

// File: rtl/gng_box_muller.sv
module gng_box_muller
    import gng_pkg::*;
#(
    parameter logic [31:0] RESET_SEED = 32'h1234_5678,
    parameter logic [31:0] SEED_KEY   = 32'h9E37_79B9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 seed_load,
    input  logic [31:0]          seed_i,
    output logic                 valid_o,
    output logic signed [OW-1:0] sample_sin_o,
    output logic signed [OW-1:0] sample_cos_o
);
    logic            adv;
    logic [UW-1:0]   u0;
    logic [U1_W-1:0] u1;
    logic [OW-1:0]   radius;
    trig_pair_t      trig;
    logic [LAT-1:0]  vpipe;

    assign adv = en && !seed_load;

    gng_urng #(.XOR_KEY(32'h0), .RESET_SEED(RESET_SEED), .OUT_W(UW)) u_src_radius (
        .clk(clk), .rst(rst), .adv(adv), .load(seed_load), .seed(seed_i), .u(u0));

    gng_urng #(.XOR_KEY(SEED_KEY), .RESET_SEED(RESET_SEED), .OUT_W(U1_W)) u_src_angle (
        .clk(clk), .rst(rst), .adv(adv), .load(seed_load), .seed(seed_i), .u(u1));

    gng_radius u_radius (.clk(clk), .rst(rst), .adv(adv), .u0(u0), .radius(radius));

    gng_trig u_trig (.clk(clk), .rst(rst), .adv(adv), .u1(u1), .trig(trig));

    // stage 6: radius times sine / cosine
    logic signed [34:0] ps_c, pc_c;
    assign ps_c = $signed({1'b0, radius}) * trig.s;
    assign pc_c = $signed({1'b0, radius}) * trig.c;

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_sin_o <= '0;
            sample_cos_o <= '0;
        end else if (adv) begin
            sample_sin_o <= OW'(ps_c >>> 15);
            sample_cos_o <= OW'(pc_c >>> 15);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || seed_load) vpipe <= '0;
        else if (en)          vpipe <= {vpipe[LAT-2:0], 1'b1};
    end
    assign valid_o = vpipe[LAT-1];

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!valid_o && sample_sin_o == 0 && sample_cos_o == 0));
    p_valid_needs_adv_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> $past(adv));
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!en && !seed_load) |=> ($stable(valid_o) && $stable(sample_sin_o) && $stable(sample_cos_o)));
    p_load_clears_valid_r4: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> !valid_o);
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (sample_sin_o <= 16'sd13700) && (sample_sin_o >= -16'sd13700) &&
        (sample_cos_o <= 16'sd13700) && (sample_cos_o >= -16'sd13700));

endmodule

// File: tb/gng_box_muller_tb.sv
module gng_box_muller_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 6;
    localparam int NSTAT      = 100000;
    localparam int NSEQ       = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        seed_load = 1'b0;
    logic [31:0] seed = 32'h0;
    logic        valid;
    logic signed [15:0] ys, yc;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gng_box_muller u_dut (
        .clk(clk), .rst(rst), .en(en), .seed_load(seed_load), .seed_i(seed),
        .valid_o(valid), .sample_sin_o(ys), .sample_cos_o(yc));

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_r(input bit ok, input string req, input string what,
                         input real act, input real lo, input real hi);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %f expected %f..%f", req, what, act, lo, hi);
        end
    endtask

    task automatic load(input logic [31:0] s);
        seed = s;
        seed_load = 1'b1;
        tick();
        seed_load = 1'b0;
    endtask

    task automatic fill_latency(output int n);
        en = 1'b1;
        n = 0;
        while (!valid && n < 20) begin
            tick();
            n++;
        end
    endtask

    task automatic grab(input logic [31:0] s, output logic [31:0] pk [NSEQ]);
        int n;
        load(s);
        fill_latency(n);
        chk(n == LAT, "R2", "fill edges after load", n, LAT);
        for (int i = 0; i < NSEQ; i++) begin
            pk[i] = {ys, yc};
            tick();
        end
    endtask

    initial begin
        logic [31:0] seq_a [NSEQ];
        logic [31:0] seq_b [NSEQ];
        logic [31:0] seq_c [NSEQ];
        int   n, cnt, diff, same;
        bit   ok;
        logic signed [15:0] hs, hc;
        logic hv;
        real  sa, sb, qa, qb, xab, ma, mb, va, vb, absum, a, b, rho;
        int   over, beyond;

        // R1: reset state
        repeat (3) tick();
        chk(valid == 1'b0 && ys == 0 && yc == 0, "R1", "outputs during reset", {valid, ys}, 0);
        rst = 1'b0;
        tick();
        chk(valid == 1'b0 && ys == 0 && yc == 0, "R1", "outputs after reset, en low", {valid, ys}, 0);

        // R2: fill from reset
        fill_latency(n);
        chk(n == LAT, "R2", "fill edges after reset", n, LAT);

        // R3: hold while stalled
        en = 1'b0;
        hs = ys; hc = yc; hv = valid;
        repeat (8) tick();
        ok = (ys == hs) && (yc == hc) && (valid == hv);
        chk(ok, "R3", "stall keeps sine output", ys, hs);
        chk(yc == hc && valid == hv, "R3", "stall keeps cosine/valid", yc, hc);

        // R4: load clears valid; R2: gapped enable counts only advancing edges
        load(32'h1357_9BDF);
        chk(valid == 1'b0, "R4", "valid after seed load", valid, 0);
        cnt = 0;
        ok = 1'b1;
        for (int i = 0; i < 14; i++) begin
            en = (i % 2 == 0);
            tick();
            if (i % 2 == 0) cnt++;
            if (valid != (cnt >= LAT)) ok = 1'b0;
        end
        chk(ok, "R2", "valid with enable on alternate cycles", cnt, LAT);

        // R4: determinism and seed sensitivity
        grab(32'hC0FF_EE01, seq_a);
        grab(32'h0BAD_F00D, seq_b);
        grab(32'hC0FF_EE01, seq_c);
        diff = 0; same = 0;
        for (int i = 0; i < NSEQ; i++) begin
            if (seq_a[i] != seq_b[i]) diff++;
            if (seq_a[i] == seq_c[i]) same++;
        end
        chk(same == NSEQ, "R4", "same seed repeats sequence", same, NSEQ);
        chk(diff > NSEQ/2, "R4", "different seed differs", diff, NSEQ);

        // R10: zero seed still runs
        load(32'h0);
        fill_latency(n);
        chk(n == LAT, "R10", "fill edges after zero seed", n, LAT);
        sa = 0.0; qa = 0.0; same = 0; hs = ys;
        for (int i = 0; i < 2000; i++) begin
            a = real'(ys) / 2048.0;
            sa += a; qa += a * a;
            if (ys == hs) same++;
            tick();
        end
        ma = sa / 2000.0;
        va = qa / 2000.0 - ma * ma;
        chk(same < 2000, "R10", "zero-seed output not constant", same, 0);
        chk_r(va >= 0.85 && va <= 1.15, "R10", "zero-seed variance", va, 0.85, 1.15);

        // R5..R9: statistics
        load(32'h2468_ACE1);
        fill_latency(n);
        sa = 0.0; sb = 0.0; qa = 0.0; qb = 0.0; xab = 0.0; absum = 0.0;
        over = 0; beyond = 0;
        for (int i = 0; i < NSTAT; i++) begin
            if (!valid) over++;
            a = real'(ys) / 2048.0;
            b = real'(yc) / 2048.0;
            sa += a; sb += b; qa += a * a; qb += b * b; xab += a * b;
            absum += (a < 0.0 ? -a : a) + (b < 0.0 ? -b : b);
            if (ys > 16'sd13700 || ys < -16'sd13700 || yc > 16'sd13700 || yc < -16'sd13700) over++;
            if (ys > 16'sd6144 || ys < -16'sd6144) beyond++;
            if (yc > 16'sd6144 || yc < -16'sd6144) beyond++;
            tick();
        end
        ma = sa / NSTAT; mb = sb / NSTAT;
        va = qa / NSTAT - ma * ma;
        vb = qb / NSTAT - mb * mb;
        rho = (xab / NSTAT - ma * mb) / $sqrt(va * vb);
        chk(over == 0, "R5", "magnitude bound 13700", over, 0);
        chk_r(absum / (2.0 * NSTAT) >= 0.77 && absum / (2.0 * NSTAT) <= 0.83, "R5",
              "mean |x| scaling", absum / (2.0 * NSTAT), 0.77, 0.83);
        chk_r(ma >= -0.03 && ma <= 0.03, "R6", "sine mean", ma, -0.03, 0.03);
        chk_r(mb >= -0.03 && mb <= 0.03, "R6", "cosine mean", mb, -0.03, 0.03);
        chk_r(va >= 0.95 && va <= 1.05, "R7", "sine variance", va, 0.95, 1.05);
        chk_r(vb >= 0.95 && vb <= 1.05, "R7", "cosine variance", vb, 0.95, 1.05);
        chk_r(rho > -0.03 && rho < 0.03, "R8", "branch correlation", rho, -0.03, 0.03);
        chk_r(real'(beyond) / (2.0 * NSTAT) >= 0.0015 && real'(beyond) / (2.0 * NSTAT) <= 0.0040,
              "R9", "fraction beyond 3 sigma", real'(beyond) / (2.0 * NSTAT), 0.0015, 0.0040);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule